// File: doc/BRIEF.md
# Four-Channel Bus Transmit Gate with Dominant Watchdog

This block sits between four protocol controllers and the drivers of four single-wire bus transceivers. Each channel has its own transmit request. A low TXD level asks for a dominant bus, and a high level asks for a recessive one. The block decides each clock cycle whether that request may actually switch the channel's driver on. It also produces the receive output that goes back to the controller.

A driver is switched on only when all of the following hold:
- the chip is in normal mode;
- no over-temperature condition is present;
- the supply monitor reports a usable battery level;
- the channel has been armed by a high TXD level seen in normal mode;
- the channel's long-dominant watchdog has not expired.

The watchdog runs separately on every channel. It stops a stuck-low TXD from blocking its bus, and it does not disturb the other three buses.

The supply condition comes from two comparator flags, a low threshold and a high threshold. They are combined with hysteresis. Reception continues under every transmit block. The over-temperature flag also pulls every receive output low for as long as it is present.

Top module: `quad_tx_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every `drv_on_o` bit is 0. The stored battery state resets to "not usable", so no driver turns on until `vbat_high_i` has been seen at a clock edge.
- R2: TXD value 0 requests dominant and 1 requests recessive. `drv_on_o[c]` is 1 exactly when all of these hold:
  - `normal_mode_i` is 1;
  - `therm_sd_i` is 0;
  - the registered battery state is usable;
  - channel c is armed;
  - channel c is not timed out;
  - `txd_i[c]` is 0.
- R3: A channel becomes armed at the clock edge where `normal_mode_i` is 1 and its `txd_i` bit is 1. It is disarmed at every edge where `normal_mode_i` is 0. A high-then-low TXD sequence inside normal mode therefore drives in the low cycle.
- R4: If `txd_i[c]` is 0 when normal mode is entered, channel c does not drive until TXD has been 1 for at least one clock edge in normal mode.
- R5: Once armed, a channel held continuously at TXD 0 drives for at most TIMEOUT_CYC consecutive cycles and then releases. It drives again only after TXD has been 1 for at least one clock edge.
- R6: A timeout or TXD activity on one channel has no effect on the drive or receive output of any other channel.
- R7: While `therm_sd_i` is 1, all `drv_on_o` bits and all `rxd_o` bits are 0 in the same cycle. Both return to their normal values in the first cycle after `therm_sd_i` falls.
- R8: The battery state is set to "not usable" at an edge where `vbat_low_i` is 1. This has priority. It is set to "usable" at an edge where only `vbat_high_i` is 1. With both flags 0 it holds. The battery state never changes `rxd_o`.
- R9: Without thermal shutdown, `rxd_o[c]` equals the inverse of `bus_dom_i[c]` in normal mode (bus dominant = 1 gives RXD 0). Outside normal mode it is 1.
- R10: Leaving normal mode clears each channel's timeout count. After re-entry and re-arming, a full TIMEOUT_CYC window of drive is available again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_i | input | NUM_CH | Per-channel transmit data, 0 = dominant request |
| normal_mode_i | input | 1 | 1 while the mode controller is in normal mode |
| therm_sd_i | input | 1 | 1 while over-temperature shutdown is active |
| vbat_low_i | input | 1 | 1 when the supply is below the low monitor threshold |
| vbat_high_i | input | 1 | 1 when the supply is above the high monitor threshold |
| bus_dom_i | input | NUM_CH | Per-channel receiver comparator, 1 = bus dominant |
| drv_on_o | output | NUM_CH | Per-channel driver command, 1 = pull bus dominant |
| rxd_o | output | NUM_CH | Per-channel receive output, 0 = dominant or thermal hold |

## Verification
The embedded assertions check several properties on every cycle:
- no channel drives for more than TIMEOUT_CYC cycles in a row;
- a channel entering normal mode with TXD low stays off;
- a high-to-low TXD step in an enabled normal mode drives at once;
- the battery state follows its hysteresis rule;
- thermal shutdown silences all drivers and receive outputs.

Some behaviour can only be shown by the bench's scenarios:
- the exact length of the drive window;
- that a timed-out channel leaves its neighbours untouched;
- that the window is restored after a trip out of normal mode;
- the long mixed sequences of mode, temperature and supply changes against an independent reference model.

// File: rtl/qtg_pkg.sv
package qtg_pkg;

    // Registered supply condition used to qualify transmission.
    typedef enum logic {
        BATT_BLOCKED = 1'b0,
        BATT_USABLE  = 1'b1
    } batt_state_e;

    // Width needed to hold values 0..limit inclusive.
    function automatic int cnt_width(input int limit);
        int w;
        w = 1;
        while ((1 << w) <= limit) w++;
        return w;
    endfunction

endpackage

// File: rtl/qtg_batt_hyst.sv
module qtg_batt_hyst
    import qtg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vbat_low_i,
    input  logic vbat_high_i,
    output logic usable_o
);

    typedef struct packed {
        batt_state_e state;
    } batt_reg_t;

    batt_reg_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (vbat_low_i) begin
            nxt_d.state = BATT_BLOCKED;
        end else if (vbat_high_i) begin
            nxt_d.state = BATT_USABLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= BATT_BLOCKED;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign usable_o = (cur_q.state == BATT_USABLE);

    // R8: low threshold crossing blocks on the next cycle
    a_r8_low_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        vbat_low_i |=> !usable_o);

    // R8: high threshold alone re-enables on the next cycle
    a_r8_high_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (vbat_high_i && !vbat_low_i) |=> usable_o);

    // R8: inside the hysteresis band the state holds
    a_r8_band_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!vbat_high_i && !vbat_low_i) |=> $stable(usable_o));

endmodule

// File: rtl/qtg_chan.sv
module qtg_chan
    import qtg_pkg::*;
#(
    parameter int TIMEOUT_CYC = 28000,
    parameter int CNT_W       = cnt_width(TIMEOUT_CYC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_i,
    input  logic normal_i,
    input  logic tx_allow_i,
    output logic drv_o
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } chan_reg_t;

    chan_reg_t cur_q, nxt_d;
    logic      expired;

    always_comb begin
        nxt_d = cur_q;
        if (!normal_i) begin
            // R10: any exit from normal mode disarms and clears the count
            nxt_d.armed = 1'b0;
            nxt_d.cnt   = '0;
        end else if (txd_i) begin
            // R3: a recessive request arms the channel and resets the watchdog
            nxt_d.armed = 1'b1;
            nxt_d.cnt   = '0;
        end else if (cur_q.armed && (cur_q.cnt != LIMIT)) begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.armed <= 1'b0;
            cur_q.cnt   <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign expired = (cur_q.cnt == LIMIT);
    assign drv_o   = normal_i & tx_allow_i & cur_q.armed & ~expired & ~txd_i;

    // Assertion support: length of the current run of driven cycles.
    logic [CNT_W-1:0] run_q;
    logic             seen_edge_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q       <= '0;
            seen_edge_q <= 1'b0;
        end else begin
            seen_edge_q <= 1'b1;
            if (!drv_o) begin
                run_q <= '0;
            end else if (run_q != LIMIT) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R5: never more than TIMEOUT_CYC consecutive driven cycles
    a_r5_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        drv_o |-> (run_q < LIMIT));

    // R4: entering normal mode with TXD low never drives
    a_r4_entry_low_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge_q && $rose(normal_i) && !txd_i) |-> !drv_o);

    // R3: high-to-low step inside an enabled normal mode drives at once
    a_r3_edge_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge_q && normal_i && $past(normal_i) && $past(txd_i)
         && !txd_i && tx_allow_i) |-> drv_o);

endmodule

// File: rtl/quad_tx_gate.sv
module quad_tx_gate
    import qtg_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int TIMEOUT_CYC = 28000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] txd_i,
    input  logic              normal_mode_i,
    input  logic              therm_sd_i,
    input  logic              vbat_low_i,
    input  logic              vbat_high_i,
    input  logic [NUM_CH-1:0] bus_dom_i,
    output logic [NUM_CH-1:0] drv_on_o,
    output logic [NUM_CH-1:0] rxd_o
);

    localparam int CNT_W = cnt_width(TIMEOUT_CYC);

    logic batt_usable;
    logic tx_allow;

    qtg_batt_hyst i_batt (
        .clk         (clk),
        .rst_n       (rst_n),
        .vbat_low_i  (vbat_low_i),
        .vbat_high_i (vbat_high_i),
        .usable_o    (batt_usable)
    );

    // Shared qualifier: temperature and supply block all channels at once.
    assign tx_allow = batt_usable & ~therm_sd_i;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        qtg_chan #(
            .TIMEOUT_CYC (TIMEOUT_CYC),
            .CNT_W       (CNT_W)
        ) i_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .txd_i      (txd_i[c]),
            .normal_i   (normal_mode_i),
            .tx_allow_i (tx_allow),
            .drv_o      (drv_on_o[c])
        );

        always_comb begin
            if (therm_sd_i) begin
                rxd_o[c] = 1'b0;
            end else if (normal_mode_i) begin
                rxd_o[c] = ~bus_dom_i[c];
            end else begin
                rxd_o[c] = 1'b1;
            end
        end
    end

    // R7: over-temperature silences every driver and holds RXD low
    a_r7_thermal_silence: assert property (@(posedge clk) disable iff (!rst_n)
        therm_sd_i |-> (drv_on_o == '0 && rxd_o == '0));

    // R2: a driver is never on outside normal mode or with recessive request
    a_r2_no_stray_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv_on_o & txd_i) == '0) && (normal_mode_i || drv_on_o == '0));

endmodule

// File: tb/test_quad_tx_gate.sv
module test_quad_tx_gate;

    localparam int N  = 4;
    localparam int TO = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] txd = '1;
    logic         normal = 1'b0;
    logic         therm = 1'b0;
    logic         blow = 1'b0;
    logic         bhigh = 1'b0;
    logic [N-1:0] busdom = '0;
    logic [N-1:0] drv;
    logic [N-1:0] rxd;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Reference model state
    bit       m_ok;
    bit [N-1:0] m_armed;
    int       m_cnt [N];
    logic [N-1:0] last_drv;

    always #5 clk = ~clk;

    quad_tx_gate #(.NUM_CH(N), .TIMEOUT_CYC(TO)) i_quad_tx_gate (
        .clk(clk), .rst_n(rst_n), .txd_i(txd), .normal_mode_i(normal),
        .therm_sd_i(therm), .vbat_low_i(blow), .vbat_high_i(bhigh),
        .bus_dom_i(busdom), .drv_on_o(drv), .rxd_o(rxd)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] exp_drv();
        logic [N-1:0] e;
        for (int c = 0; c < N; c++)
            e[c] = normal && !therm && m_ok && m_armed[c] && (m_cnt[c] < TO) && !txd[c];
        return e;
    endfunction

    function automatic logic [N-1:0] exp_rxd();
        if (therm) return '0;
        if (normal) return ~busdom;
        return '1;
    endfunction

    task automatic model_reset();
        m_ok = 0;
        m_armed = '0;
        for (int c = 0; c < N; c++) m_cnt[c] = 0;
    endtask

    task automatic model_edge();
        if (blow) m_ok = 0;
        else if (bhigh) m_ok = 1;
        for (int c = 0; c < N; c++) begin
            if (!normal) begin
                m_armed[c] = 0; m_cnt[c] = 0;
            end else if (txd[c]) begin
                m_armed[c] = 1; m_cnt[c] = 0;
            end else if (m_armed[c] && m_cnt[c] < TO) begin
                m_cnt[c]++;
            end
        end
    endtask

    // Called just after a negedge with inputs already set.
    task automatic cyc();
        #1;
        last_drv = drv;
        check(drv === exp_drv(), "R2 drive model", drv, exp_drv());
        check(rxd === exp_rxd(), "R9 receive model", rxd, exp_rxd());
        @(posedge clk);
        if (rst_n) model_edge();
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int runlen;
        void'($urandom(32'h5EED_0424));
        model_reset();
        @(negedge clk);
        repeat (3) cyc();
        #1;
        check(drv === '0, "R1 drive off in reset", drv, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: battery state starts blocked; normal mode with armed channel stays off
        normal = 1; txd = '1;
        cyc();
        txd = '0;
        cyc();
        check(last_drv === '0, "R1 no drive before battery high", last_drv, '0);

        // R4: enter normal with TXD low: no drive even after battery usable
        normal = 0; cyc();
        bhigh = 1; cyc(); bhigh = 0;
        normal = 1; txd = '0;
        repeat (3) cyc();
        check(last_drv === '0, "R4 entry low stays silent", last_drv, '0);

        // R3: high then low drives immediately
        txd = '1; cyc();
        txd = '0; cyc();
        check(last_drv === '1, "R3 high-to-low drives", last_drv, '1);

        // R5/R6: channel 0 times out while channel 1 toggles
        txd = '1; cyc();
        runlen = 1;
        txd[0] = 0; txd[1] = 0;
        for (int k = 0; k < TO + 6; k++) begin
            txd[1] = (k % 4 == 3);
            cyc();
            if (k >= 1 && last_drv[0]) runlen++;
            if (k == TO + 2) check(last_drv[1] === !txd[1], "R6 neighbour unaffected",
                                   last_drv, {N{1'b0}} | 4'b0010);
        end
        check(runlen == TO, "R5 drive window length", runlen[N-1:0], TO[N-1:0]);
        check(last_drv[0] === 1'b0, "R5 released after timeout", last_drv, '0);
        txd[0] = 1; cyc();
        txd[0] = 0; cyc();
        check(last_drv[0] === 1'b1, "R5 rearm after high", last_drv, 4'b0001);

        // R10: leave normal mid-window, return, full window available
        txd = '1; cyc();
        txd = '0; repeat (8) cyc();
        normal = 0; cyc();
        normal = 1; txd = '1; cyc();
        txd = '0; runlen = 0;
        for (int k = 0; k < TO + 3; k++) begin
            cyc();
            if (last_drv[2]) runlen++;
        end
        check(runlen == TO, "R10 window restored", runlen[N-1:0], TO[N-1:0]);

        // R7: thermal shutdown silences all and holds RXD low
        txd = '1; cyc();
        txd = '0; busdom = '0; therm = 1;
        #1;
        check(drv === '0 && rxd === '0, "R7 thermal silence", drv | rxd, '0);
        cyc();
        therm = 0;
        #1;
        check(rxd === '1 && drv === '1, "R7 thermal release", rxd & drv, '1);
        cyc();

        // R8: low threshold blocks next cycle, band holds, high re-enables
        txd = '1; cyc();
        txd = '0; blow = 1; busdom = 4'b0101; cyc();
        blow = 0; cyc();
        check(last_drv === '0, "R8 low blocks", last_drv, '0);
        #1;
        check(rxd === 4'b1010, "R8 reception continues", rxd, 4'b1010);
        bhigh = 1; cyc(); bhigh = 0;
        txd = '1; cyc(); txd = '0; cyc();
        check(last_drv === '1, "R8 high re-enables", last_drv, '1);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            for (int c = 0; c < N; c++) if ($urandom_range(7) == 0) txd[c] = ~txd[c];
            if ($urandom_range(99) == 0) normal = ~normal;
            if ($urandom_range(149) == 0) therm = ~therm;
            blow = ($urandom_range(59) == 0);
            bhigh = ($urandom_range(19) == 0);
            busdom = N'($urandom);
            cyc();
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule